// File: doc/BRIEF.md
# Pulse-Length Frame Sequencer

This block turns a single framing wire into the frame bookkeeping that time-resolved image storage needs. The only thing carried on the wire is how long each high pulse lasts. The block measures every high pulse in system clock cycles and sorts it into one of three classes:

- a short "restart" mark;
- a long "advance" mark;
- a glitch, which is dropped.

A low line means a dead frame: nothing may be stored while it lasts.

A restart mark on its own never opens acquisition. It only arms the sequencer and sets the frame index back to zero. The next advance mark turns frame 0 into the first live frame. After that, every further advance mark moves on to the next frame. The index wraps at the largest frame count that fits one memory bank for the selected image size; a parameter makes it saturate there instead.

A base address for the current frame is presented with the index, ready to be added to the pixel offset by the storage path. Histogram memory access itself is outside this block.

Top module: `pulse_frame_seq`

## Requirements
- R1: After reset the frame index is 0, the live flag is 0 and the base address is 0.
- R2: A high pulse of 4 to 7 clock cycles (40 to 70 ns at 10 ns per cycle) is a restart mark. It sets the frame index to 0, arms the sequencer and leaves the live flag at 0.
- R3: A high pulse of 10 or more cycles (100 ns or more) that comes before any restart mark since reset is ignored. The index does not change and the live flag stays 0.
- R4: The first advance pulse after a restart mark makes frame 0 live. The live flag rises while the line is still high, and the index stays 0.
- R5: Each later advance pulse raises the index by one and sets the live flag while the line stays high.
- R6: The live flag falls once the line goes low, no more than 3 cycles after the line falls at the input.
- R7: High pulses of 1 to 3 cycles or of 8 to 9 cycles are glitches. They change neither the index nor the live flag.
- R8: When the index is at the last frame, an advance wraps it to 0 (this is the default; saturation can be selected instead). The frame counts are 256 for size code 1 (512x512), 64 for code 2 (1024x1024) and 16 for code 3 (2048x2048). These follow from a bank of 2^26 words of 32 bits.
- R9: The base address is the frame index times the pixel count times 4. That is the index shifted left by 20, 22 or 24 bits for size codes 1, 2 and 3. It follows a change of the index within one cycle.
- R10: Any other size code (0 or 4 to 15) allows one frame only. The index then stays 0 on advances, and the base address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_line_i | input | 1 | Framing wire; its high-pulse length carries the command |
| img_size_i | input | 4 | Image size code (1: 512x512, 2: 1024x1024, 3: 2048x2048) |
| frame_num_o | output | 12 | Current live frame index |
| live_o | output | 1 | 1 while the current frame is live, 0 while it is dead |
| base_addr_o | output | 28 | Byte base address of the current frame |

## Verification
The bench models the sequencer state, the frame index and the size limits by arithmetic alone. It compares the ports a few cycles after every pulse, so a wrong decision on any single pulse shows in the index or the base address before the next pulse begins.

A misclassified pulse length would break the sweep over every width from 1 to 15 cycles right away. A wrong arming state would show as a live flag during a pulse that should be ignored. Off-by-one errors in the wrap limit appear at the end of a full run through each image size. A stuck live flag appears within the first few low cycles after a long pulse.

// File: rtl/pulse_frame_seq_pkg.sv
package pulse_frame_seq_pkg;

  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_ARMED = 2'd1,
    TRK_RUN   = 2'd2
  } trk_state_e;

  localparam logic [3:0] SIZE_512 = 4'd1;
  localparam logic [3:0] SIZE_1K  = 4'd2;
  localparam logic [3:0] SIZE_2K  = 4'd3;

  // log2 of pixels per image; 0 marks a code that allows no time-resolved frames
  function automatic logic [4:0] pix_log2(input logic [3:0] code);
    logic [4:0] r;
    case (code)
      SIZE_512: r = 5'd18;
      SIZE_1K:  r = 5'd20;
      SIZE_2K:  r = 5'd22;
      default:  r = 5'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= 1'b0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pfs_width_meter.sv
module pfs_width_meter #(
  parameter int ZERO_MIN = 4,
  parameter int ZERO_MAX = 7,
  parameter int NEXT_MIN = 10,
  localparam int CW = $clog2(NEXT_MIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s_i,
  output logic          fall_o,
  output logic          zero_mark_o,
  output logic          next_mark_o,
  output logic [CW-1:0] width_o
);
  localparam logic [CW-1:0] ZMIN_C = CW'(ZERO_MIN);
  localparam logic [CW-1:0] ZMAX_C = CW'(ZERO_MAX);
  localparam logic [CW-1:0] NSAT_C = CW'(NEXT_MIN);
  localparam logic [CW-1:0] NHIT_C = CW'(NEXT_MIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          line_q;

  // count high cycles, saturating at the advance threshold
  always_comb begin
    cnt_d = cnt_q;
    if (line_s_i) begin
      if (cnt_q != NSAT_C) cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      line_q <= line_s_i;
    end
  end

  assign fall_o      = line_q & ~line_s_i;
  assign width_o     = cnt_q;
  assign zero_mark_o = fall_o && (cnt_q >= ZMIN_C) && (cnt_q <= ZMAX_C);
  assign next_mark_o = line_s_i && (cnt_q == NHIT_C);
endmodule

// File: rtl/pfs_frame_tracker.sv
module pfs_frame_tracker
  import pulse_frame_seq_pkg::*;
#(
  parameter int FRAME_W  = 12,
  parameter bit SATURATE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_s_i,
  input  logic               fall_i,
  input  logic               zero_mark_i,
  input  logic               next_mark_i,
  input  logic [FRAME_W-1:0] last_frame_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               live_o,
  output trk_state_e         state_o
);
  trk_state_e         state_q, state_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               live_q, live_d;
  logic               upd_en;

  assign upd_en = zero_mark_i | next_mark_i | fall_i;

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    live_d  = live_q;
    if (zero_mark_i) begin
      state_d = TRK_ARMED;
      frame_d = '0;
      live_d  = 1'b0;
    end else if (next_mark_i) begin
      case (state_q)
        TRK_ARMED: begin
          state_d = TRK_RUN;
          frame_d = '0;
          live_d  = 1'b1;
        end
        TRK_RUN: begin
          live_d = 1'b1;
          if (frame_q >= last_frame_i) frame_d = SATURATE ? last_frame_i : '0;
          else                         frame_d = frame_q + 1'b1;
        end
        default: ;
      endcase
    end else if (!line_s_i) begin
      live_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
      frame_q <= '0;
      live_q  <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      frame_q <= frame_d;
      live_q  <= live_d;
    end
  end

  assign frame_o = frame_q;
  assign live_o  = live_q;
  assign state_o = state_q;
endmodule

// File: rtl/pfs_addr_map.sv
module pfs_addr_map
  import pulse_frame_seq_pkg::*;
#(
  parameter int FRAME_W         = 12,
  parameter int BANK_WORDS_LOG2 = 26,
  localparam int ADDR_W = BANK_WORDS_LOG2 + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         size_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] last_frame_o,
  output logic [ADDR_W-1:0]  base_o
);
  logic [4:0]        plog;
  logic [ADDR_W-1:0] base_d, base_q;
  logic              base_en;
  int                fr_log2;

  assign plog = pix_log2(size_i);

  always_comb begin
    fr_log2 = BANK_WORDS_LOG2 - int'(plog);
    if (plog == 5'd0)          last_frame_o = '0;
    else if (fr_log2 >= FRAME_W) last_frame_o = '1;
    else                       last_frame_o = FRAME_W'((1 << fr_log2) - 1);
  end

  always_comb begin
    if (plog == 5'd0) base_d = '0;
    else base_d = {{(ADDR_W-FRAME_W){1'b0}}, frame_i} << (int'(plog) + 2);
  end

  assign base_en = (base_d != base_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  assign base_o = base_q;
endmodule

// File: rtl/pulse_frame_seq.sv
module pulse_frame_seq
  import pulse_frame_seq_pkg::*;
#(
  parameter int FRAME_W         = 12,
  parameter int BANK_WORDS_LOG2 = 26,
  parameter int CLK_PERIOD_NS   = 10,
  parameter int ZERO_MIN_NS     = 40,
  parameter int ZERO_MAX_NS     = 70,
  parameter int NEXT_MIN_NS     = 100,
  parameter int SYNC_STAGES     = 2,
  parameter bit SATURATE        = 1'b0,
  localparam int ADDR_W = BANK_WORDS_LOG2 + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_line_i,
  input  logic [3:0]        img_size_i,
  output logic [FRAME_W-1:0] frame_num_o,
  output logic              live_o,
  output logic [ADDR_W-1:0] base_addr_o
);
  localparam int ZERO_MIN_CYC = ZERO_MIN_NS / CLK_PERIOD_NS;
  localparam int ZERO_MAX_CYC = ZERO_MAX_NS / CLK_PERIOD_NS;
  localparam int NEXT_MIN_CYC = NEXT_MIN_NS / CLK_PERIOD_NS;
  localparam int WCW          = $clog2(NEXT_MIN_CYC + 1);

  logic               rst_meta_q, rst_sync_q;
  logic               line_s;
  logic               fall, zero_mark, next_mark;
  logic [WCW-1:0]     hi_width;
  logic [FRAME_W-1:0] last_frame;
  trk_state_e         trk_state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pfs_sync #(.STAGES(SYNC_STAGES)) line_sync_i (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_i   (frame_line_i),
    .q_o   (line_s)
  );

  pfs_width_meter #(
    .ZERO_MIN (ZERO_MIN_CYC),
    .ZERO_MAX (ZERO_MAX_CYC),
    .NEXT_MIN (NEXT_MIN_CYC)
  ) meter_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .line_s_i    (line_s),
    .fall_o      (fall),
    .zero_mark_o (zero_mark),
    .next_mark_o (next_mark),
    .width_o     (hi_width)
  );

  pfs_frame_tracker #(
    .FRAME_W  (FRAME_W),
    .SATURATE (SATURATE)
  ) tracker_i (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .line_s_i     (line_s),
    .fall_i       (fall),
    .zero_mark_i  (zero_mark),
    .next_mark_i  (next_mark),
    .last_frame_i (last_frame),
    .frame_o      (frame_num_o),
    .live_o       (live_o),
    .state_o      (trk_state)
  );

  pfs_addr_map #(
    .FRAME_W         (FRAME_W),
    .BANK_WORDS_LOG2 (BANK_WORDS_LOG2)
  ) addr_i (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .size_i       (img_size_i),
    .frame_i      (frame_num_o),
    .last_frame_o (last_frame),
    .base_o       (base_addr_o)
  );
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk
  import pulse_frame_seq_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int ADDR_W  = 28,
  parameter int WCW     = 4,
  parameter int ZMIN    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_s,
  input logic               fall,
  input logic               zero_mark,
  input logic [WCW-1:0]     hi_width,
  input trk_state_e         trk_state,
  input logic [FRAME_W-1:0] frame_num_o,
  input logic               live_o,
  input logic [ADDR_W-1:0]  base_addr_o
);
  // R2
  zero_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_mark |=> (frame_num_o == '0) && !live_o);

  // R3
  idle_no_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_state == TRK_IDLE) |-> !live_o);

  // R5
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_num_o != $past(frame_num_o)) |->
      ((frame_num_o == '0) || (frame_num_o == $past(frame_num_o) + 1'b1)));

  // R6
  dead_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_s |=> !live_o);

  // R7
  glitch_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && (hi_width < WCW'(ZMIN))) |=> $stable(frame_num_o) && !live_o);

  // R9
  base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_num_o) == '0 && $stable(frame_num_o)) |-> (base_addr_o == '0));
endmodule

bind pulse_frame_seq pfs_chk #(
  .FRAME_W (FRAME_W),
  .ADDR_W  (ADDR_W),
  .WCW     (WCW),
  .ZMIN    (ZERO_MIN_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_q),
  .line_s      (line_s),
  .fall        (fall),
  .zero_mark   (zero_mark),
  .hi_width    (hi_width),
  .trk_state   (trk_state),
  .frame_num_o (frame_num_o),
  .live_o      (live_o),
  .base_addr_o (base_addr_o)
);

// File: tb/pulse_frame_seq_tb_top.sv
module pulse_frame_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic        line;
  logic [3:0]  size;
  logic [11:0] frame_num;
  logic        live;
  logic [27:0] base;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model: 0 idle, 1 armed, 2 running
  int m_st = 0;
  int m_frame = 0;

  pulse_frame_seq dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_line_i (line),
    .img_size_i   (size),
    .frame_num_o  (frame_num),
    .live_o       (live),
    .base_addr_o  (base)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic expect_eq(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int plog(input int code);
    if (code >= 1 && code <= 3) return 16 + 2 * code;
    return 0;
  endfunction

  function automatic int frames_of(input int code);
    if (plog(code) == 0) return 1;
    return 1 << (26 - plog(code));
  endfunction

  function automatic longint base_of(input int code, input int fr);
    if (plog(code) == 0) return 0;
    return longint'(fr) << (plog(code) + 2);
  endfunction

  // drive a high pulse of w cycles, update the model, check ports afterwards
  task automatic pulse(input int w, input string tag);
    bit acc;
    acc = (w >= 10) && (m_st != 0);
    @(negedge clk) line = 1'b1;
    repeat (w) @(negedge clk);
    if (w >= 13) expect_eq({tag, " live while high"}, live, acc);
    line = 1'b0;
    if (w >= 4 && w <= 7) begin
      m_st = 1; m_frame = 0;
    end else if (w >= 10) begin
      if (m_st == 1) begin
        m_st = 2; m_frame = 0;
      end else if (m_st == 2) begin
        m_frame = (m_frame + 1) % frames_of(int'(size));
      end
    end
    repeat (3) @(negedge clk);
    expect_eq({tag, " R6 live after low"}, live, 0);
    repeat (3) @(negedge clk);
    expect_eq({tag, " frame"}, frame_num, m_frame);
    expect_eq({tag, " R9 base"}, base, base_of(int'(size), m_frame));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    line  = 1'b0;
    size  = 4'd1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_eq("R1 frame", frame_num, 0);
    expect_eq("R1 live", live, 0);
    expect_eq("R1 base", base, 0);

    // R3 advance before any restart mark
    pulse(16, "R3 unarmed advance");
    pulse(30, "R3 unarmed long advance");

    // R2 restart mark, R4 first live frame
    pulse(5, "R2 restart");
    pulse(16, "R4 first live");
    expect_eq("R4 index stays zero", frame_num, 0);

    // R5 advances, R9 base per frame
    pulse(16, "R5 advance a");
    pulse(10, "R5 advance at threshold");
    pulse(20, "R5 advance c");

    // R7 / R2 / R3 width sweep from a running state
    for (int w = 1; w <= 15; w++) begin
      pulse(4, "R2 rearm");
      pulse(14, "R4 relive");
      pulse(14, "R5 step");
      pulse(w, (w >= 4 && w <= 7) ? "R2 sweep" :
               (w >= 10) ? "R5 sweep" : "R7 sweep");
    end

    // R8 wrap for each size, R9 base for each size
    for (int c = 3; c >= 1; c--) begin
      size = 4'(c);
      pulse(7, "R2 restart before wrap");
      pulse(12, "R4 start wrap run");
      for (int k = 0; k < frames_of(c) + 1; k++) pulse(11, "R8 wrap run");
    end

    // R10 codes without frames
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 3) continue;
      size = 4'(c);
      pulse(6, "R10 restart");
      pulse(12, "R10 live");
      pulse(12, "R10 advance a");
      pulse(12, "R10 advance b");
      expect_eq("R10 index held", frame_num, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule